// File: doc/BRIEF.md
# Dual-Mode CRC Checksum Unit

The unit computes a CRC over a stream of bytes, in one of two selectable widths. In 16-bit mode it uses polynomial 0x1021 and shifts most-significant bit first. In 32-bit mode it uses the reflected polynomial 0xEDB88320 and shifts least-significant bit first. Every accepted byte is folded into the running value in one clock cycle. The running value lives in a 32-bit checksum register. Software reaches that register as four byte-wide read/write locations through a simple byte-wide register port. The same port also holds a control location and a status location.

What a read of the checksum returns depends on the mode and on a BUSY flag:

- While a memory-sourced calculation is busy, the checksum reads as zero.
- Once a 32-bit calculation has finished or been aborted, the checksum reads back complemented and with its bit order reversed, which is the final CRC.
- In every other case the register contents are read back unchanged. In 16-bit mode the upper half of the register reads as zero.

The memory data source is modelled only as a select bit and an external done input. Its bytes arrive on the same valid/data input as all other bytes.

Register map:

| Offset | Contents |
|--------|----------|
| 0 | Control. Bit 0 enables the unit, bit 1 selects 32-bit mode, bit 2 selects the memory source. Bit 3 is a preset command that is written but reads as 0. |
| 1 | Status. Bit 0 is BUSY. |
| 4 to 7 | Checksum bytes, least significant byte first. |

Top module: `crc_unit`

## Requirements
- R1: After reset the control location, the status location and all four checksum bytes read 0x00.
- R2: A write to offset 0 with bit 3 set loads all 32 checksum bits with one in the following cycle. Control bit 3 always reads back as 0.
- R3: While the unit is disabled, a write to offset 4+k replaces checksum bits 8k+7:8k (k = 0..3), so offset 4 holds bits 7:0 and offset 7 holds bits 31:24.
- R4: Writes to offsets 4 to 7 are ignored while the unit is enabled.
- R5: In 16-bit mode each byte accepted while enabled updates bits 15:0 by one step of the CRC with polynomial 0x1021, MSB first. After a preset, the string "123456789" yields 0x29B1.
- R6: In 32-bit mode with BUSY clear, a checksum read returns the complemented, bit-reversed register (bit 31 maps to bit 0). After a preset, "123456789" reads 0xCBF43926.
- R7: BUSY (status bit 0) is set by the first accepted byte, or by enabling the unit with the memory source selected. It clears the cycle after mem_done_i is high.
- R8: With the memory source selected and BUSY set, all checksum bytes read 0x00.
- R9: In 32-bit mode with BUSY set and the byte source selected, the checksum reads the raw register, which holds the bit-reversed reflected CRC state.
- R10: In 16-bit mode, checksum bits 31:16 read as zero and are not changed by accepted bytes.
- R11: Disabling the unit clears BUSY in the next cycle, as an abort. The 32-bit result of the bytes accepted so far then reads back in transformed form.
- R12: Bytes presented while the unit is disabled leave the checksum unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 3 | Register offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| byte_valid_i | input | 1 | Input byte valid |
| byte_i | input | 8 | Input byte |
| mem_done_i | input | 1 | Memory-sourced calculation finished |

## Verification
The 16-bit and 32-bit CRCs of "123456789" are compared against their check values 0x29B1 and 0xCBF43926:

- A wrong polynomial, shift direction or byte order is caught by these values.
- The single-byte 32-bit CRC of "A", taken with an abort, separates the abort path from the done path.

Readback is tried in each state:

- The raw busy value in 32-bit mode distinguishes the untransformed read from the transformed one.
- Zero is expected during a busy memory-sourced run.
- A register written while disabled, then read in 32-bit mode, tells lane order apart from transform errors.

Further checks cover the following:

- Writes made while enabled are ignored.
- Bytes presented while disabled have no effect.
- The upper half of the register is held in 16-bit mode.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;
  localparam int BYTE_W   = 8;
  localparam int CSUM_W   = 32;
  localparam int NARROW_W = 16;
  localparam int LANES    = CSUM_W / BYTE_W;
  localparam int LANE_W   = $clog2(LANES);
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_CSUM = 3'd4;

  // control byte layout, bit 0 at the bottom
  typedef struct packed {
    logic preset;
    logic mem_src;
    logic wide;
    logic enable;
  } ctrl_t;

  function automatic logic [CSUM_W-1:0] rev_bits(input logic [CSUM_W-1:0] v);
    logic [CSUM_W-1:0] r;
    for (int i = 0; i < CSUM_W; i++) r[i] = v[CSUM_W-1-i];
    return r;
  endfunction

  function automatic logic [NARROW_W-1:0] crc16_byte(input logic [NARROW_W-1:0] c,
                                                     input logic [BYTE_W-1:0] d,
                                                     input logic [NARROW_W-1:0] poly);
    logic [NARROW_W-1:0] r;
    r = c ^ {d, {(NARROW_W-BYTE_W){1'b0}}};
    for (int b = 0; b < BYTE_W; b++) r = r[NARROW_W-1] ? ((r << 1) ^ poly) : (r << 1);
    return r;
  endfunction

  function automatic logic [CSUM_W-1:0] crc32r_byte(input logic [CSUM_W-1:0] c,
                                                    input logic [BYTE_W-1:0] d,
                                                    input logic [CSUM_W-1:0] poly);
    logic [CSUM_W-1:0] r;
    r = c ^ {{(CSUM_W-BYTE_W){1'b0}}, d};
    for (int b = 0; b < BYTE_W; b++) r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_unit_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ctrl_we_i,
  input  ctrl_t ctrl_wdata_i,
  input  logic  data_valid_i,
  input  logic  mem_done_i,
  output logic  en_o,
  output logic  wide_o,
  output logic  mem_src_o,
  output logic  preset_o,
  output logic  busy_o,
  output logic  byte_acc_o
);
  logic en_q, wide_q, mem_q, busy_q, busy_d, en_nxt, start_mem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      wide_q <= 1'b0;
      mem_q  <= 1'b0;
    end else if (ctrl_we_i) begin
      en_q   <= ctrl_wdata_i.enable;
      wide_q <= ctrl_wdata_i.wide;
      mem_q  <= ctrl_wdata_i.mem_src;
    end
  end

  assign byte_acc_o = en_q & data_valid_i;
  assign preset_o   = ctrl_we_i & ctrl_wdata_i.preset;
  assign en_nxt     = ctrl_we_i ? ctrl_wdata_i.enable : en_q;
  assign start_mem  = ctrl_we_i & ctrl_wdata_i.enable & ctrl_wdata_i.mem_src & ~en_q;

  // disable (abort) and done win over a new start
  always_comb begin
    busy_d = busy_q;
    if (!en_nxt)                      busy_d = 1'b0;
    else if (mem_done_i)              busy_d = 1'b0;
    else if (start_mem || byte_acc_o) busy_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  assign en_o      = en_q;
  assign wide_o    = wide_q;
  assign mem_src_o = mem_q;
  assign busy_o    = busy_q;

  a_r7_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_done_i |=> !busy_o);
  a_r7_byte_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_acc_o && !mem_done_i && !(ctrl_we_i && !ctrl_wdata_i.enable) |=> busy_o);
  a_r11_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && !ctrl_wdata_i.enable |=> !busy_o && !en_o);
endmodule

// File: rtl/crc_core.sv
module crc_core
  import crc_unit_pkg::*;
#(
  parameter logic [NARROW_W-1:0] POLY_NARROW   = 16'h1021,
  parameter logic [CSUM_W-1:0]   POLY_WIDE_REF = 32'hEDB88320
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wide_i,
  input  logic              preset_i,
  input  logic              byte_acc_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              cs_we_i,
  input  logic [LANE_W-1:0] cs_lane_i,
  input  logic [BYTE_W-1:0] cs_wdata_i,
  output logic [CSUM_W-1:0] cs_o
);
  logic [CSUM_W-1:0] cs_q, cs_d, lane_wr, step_wide, step_narrow;
  logic              wr_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_wr[g*BYTE_W +: BYTE_W] =
      (cs_lane_i == LANE_W'(g)) ? cs_wdata_i : cs_q[g*BYTE_W +: BYTE_W];
  end

  // wide state is kept bit-reversed so the readback transform yields the standard result
  assign step_wide   = rev_bits(crc32r_byte(rev_bits(cs_q), data_i, POLY_WIDE_REF));
  assign step_narrow = {cs_q[CSUM_W-1:NARROW_W],
                        crc16_byte(cs_q[NARROW_W-1:0], data_i, POLY_NARROW)};
  assign wr_ok       = cs_we_i & ~en_i;

  always_comb begin
    cs_d = cs_q;
    if (preset_i)        cs_d = '1;
    else if (wr_ok)      cs_d = lane_wr;
    else if (byte_acc_i) cs_d = wide_i ? step_wide : step_narrow;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= '0;
    else         cs_q <= cs_d;
  end

  assign cs_o = cs_q;

  a_r2_preset_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |=> cs_o == '1);
  a_r4_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_we_i && en_i && !preset_i && !byte_acc_i |=> $stable(cs_o));
  a_r10_upper_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_acc_i && !wide_i && !preset_i |=> $stable(cs_o[CSUM_W-1:NARROW_W]));
  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !cs_we_i && !preset_i |=> $stable(cs_o));
endmodule

// File: rtl/crc_readback.sv
module crc_readback
  import crc_unit_pkg::*;
(
  input  logic [CSUM_W-1:0] cs_i,
  input  logic              wide_i,
  input  logic              mem_src_i,
  input  logic              busy_i,
  output logic [CSUM_W-1:0] view_o
);
  always_comb begin
    if (mem_src_i && busy_i)  view_o = '0;
    else if (wide_i && !busy_i) view_o = ~rev_bits(cs_i);
    else if (wide_i)          view_o = cs_i;
    else                      view_o = {{(CSUM_W-NARROW_W){1'b0}}, cs_i[NARROW_W-1:0]};
  end
endmodule

// File: rtl/crc_unit.sv
module crc_unit
  import crc_unit_pkg::*;
#(
  parameter logic [NARROW_W-1:0] POLY_NARROW   = 16'h1021,
  parameter logic [CSUM_W-1:0]   POLY_WIDE_REF = 32'hEDB88320
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              mem_done_i
);
  logic              en, wide, mem_src, preset, busy, byte_acc, ctrl_we, cs_we, is_cs;
  logic [LANE_W-1:0] lane;
  logic [CSUM_W-1:0] cs, view;
  ctrl_t             ctrl_wdata;

  assign is_cs      = reg_addr_i >= OFF_CSUM;
  assign lane       = reg_addr_i[LANE_W-1:0];
  assign ctrl_we    = reg_we_i & (reg_addr_i == OFF_CTRL);
  assign cs_we      = reg_we_i & is_cs;
  assign ctrl_wdata = ctrl_t'(reg_wdata_i[$bits(ctrl_t)-1:0]);

  crc_ctrl i_ctrl (
    .clk_i, .rst_ni,
    .ctrl_we_i   (ctrl_we),
    .ctrl_wdata_i(ctrl_wdata),
    .data_valid_i(byte_valid_i),
    .mem_done_i,
    .en_o        (en),
    .wide_o      (wide),
    .mem_src_o   (mem_src),
    .preset_o    (preset),
    .busy_o      (busy),
    .byte_acc_o  (byte_acc)
  );

  crc_core #(.POLY_NARROW(POLY_NARROW), .POLY_WIDE_REF(POLY_WIDE_REF)) i_core (
    .clk_i, .rst_ni,
    .en_i      (en),
    .wide_i    (wide),
    .preset_i  (preset),
    .byte_acc_i(byte_acc),
    .data_i    (byte_i),
    .cs_we_i   (cs_we),
    .cs_lane_i (lane),
    .cs_wdata_i(reg_wdata_i),
    .cs_o      (cs)
  );

  crc_readback i_readback (
    .cs_i     (cs),
    .wide_i   (wide),
    .mem_src_i(mem_src),
    .busy_i   (busy),
    .view_o   (view)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == OFF_CTRL)      reg_rdata_o[2:0] = {mem_src, wide, en};
    else if (reg_addr_i == OFF_STAT) reg_rdata_o[0]   = busy;
    else if (is_cs)                  reg_rdata_o      = view[lane*BYTE_W +: BYTE_W];
  end

  a_r8_mem_busy_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_src && busy |-> view == '0);
  a_r6_final_transform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide && !busy |-> rev_bits(~view) == cs);
  a_r10_upper_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide |-> view[CSUM_W-1:NARROW_W] == '0);
endmodule

// File: tb/test_crc_unit.sv
module test_crc_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_d = '0;
  logic       mem_done = 1'b0;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  crc_unit i_crc_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .byte_valid_i(byte_valid), .byte_i(byte_d), .mem_done_i(mem_done)
  );

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // monitor: compare each queued expectation one edge after the address is set
  initial forever begin
    @(posedge clk); #2;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #3;
  endtask

  task automatic rd32(input logic [31:0] e, input string t);
    for (int k = 0; k < 4; k++) rd(3'(4 + k), e[8*k +: 8], t);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_d = b; byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send(s[i]);
  endtask

  task automatic pulse_done();
    @(negedge clk);
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, 8'h00, "R1 ctrl");
    rd(3'd1, 8'h00, "R1 status");
    rd32(32'h0, "R1 checksum");

    // R3 lane write while disabled, 16-bit mode
    wr(3'd4, 8'h78); wr(3'd5, 8'h56); wr(3'd6, 8'h34); wr(3'd7, 8'h12);
    rd(3'd4, 8'h78, "R3 byte0");
    rd(3'd5, 8'h56, "R3 byte1");
    rd(3'd6, 8'h00, "R10 byte2 zero in 16-bit");
    rd(3'd7, 8'h00, "R10 byte3 zero in 16-bit");
    wr(3'd0, 8'h02);
    rd32(~rev32(32'h12345678), "R3 R6 lanes via 32-bit view");

    // R2 preset in 16-bit mode
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h00, "R2 preset bit reads 0");
    rd(3'd4, 8'hFF, "R2 preset byte0");
    rd(3'd5, 8'hFF, "R2 preset byte1");

    // R5 16-bit check string
    wr(3'd0, 8'h01);
    rd(3'd1, 8'h00, "R7 idle before first byte");
    send_str("123456789");
    rd(3'd1, 8'h01, "R7 busy after byte");
    wr(3'd4, 8'h00);
    rd(3'd4, 8'hB1, "R4 R5 crc16 low (write ignored)");
    rd(3'd5, 8'h29, "R5 crc16 high");
    rd(3'd6, 8'h00, "R10 byte2 in 16-bit");
    wr(3'd0, 8'h00);
    rd(3'd1, 8'h00, "R11 disable clears busy");
    send(8'h5A);
    rd(3'd4, 8'hB1, "R12 byte ignored when disabled");
    wr(3'd0, 8'h02);
    rd32(~rev32(32'hFFFF29B1), "R10 upper bits held");

    // R6 R9 32-bit check string, finish by done
    wr(3'd0, 8'h0A);
    wr(3'd0, 8'h03);
    send_str("123456789");
    rd(3'd1, 8'h01, "R7 busy 32-bit");
    wr(3'd7, 8'h00);
    rd32(rev32(~32'hCBF43926), "R4 R9 raw while busy");
    pulse_done();
    rd(3'd1, 8'h00, "R7 done clears busy");
    rd32(32'hCBF43926, "R6 crc32 result");

    // R8 R11 memory source, abort
    wr(3'd0, 8'h02);
    wr(3'd0, 8'h0A);
    wr(3'd0, 8'h07);
    rd(3'd1, 8'h01, "R7 busy on mem enable");
    send(8'h41);
    rd32(32'h0, "R8 mem busy reads zero");
    wr(3'd0, 8'h06);
    rd(3'd1, 8'h00, "R11 abort clears busy");
    rd32(32'hD3D99E8B, "R11 aborted crc32 of A");

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule